// File: doc/BRIEF.md
# Gated Clock-Enable Crossbar

This block turns four source clock-enable streams, all living in one system clock domain, into up to sixteen derived enable streams. Every output channel picks one of the four sources, lets through only every 2^n-th pulse of that source, and can be switched off on its own. The result is a set of single-cycle enable pulses that downstream logic uses in place of separately generated clocks.

Three shared control words hold the settings. A disable word carries one bit per channel, while a routing word and a rate word each carry one 2-bit field per channel. Software reaches them through a plain address/data port with a write strobe and a combinational read path. A new route or rate only takes hold once the channel finishes the divided period it is in, so an output never produces a short period. A disabled channel stays silent and its pulse counter is cleared. When the channel is enabled again it counts a full period from zero.

Top module: `clk_en_xbar`

## Requirements
- R1: After reset the disable word reads all ones, the routing and rate words read zero, and every `ch_en` bit is 0.
- R2: Byte offset 0x0 holds the disable word (bit i belongs to channel i). Offset 0x4 holds the routing word and offset 0x8 the rate word, where channel i owns bits [2i+1:2i] in each. A write stores `bus_wdata` and a read returns the stored value.
- R3: A write to any offset other than 0x0, 0x4 or 0x8 changes no stored setting, and a read of such an offset returns zero.
- R4: While a channel's disable bit is 1, its `ch_en` bit is 0 from the cycle after the write edge onwards. Other channels are unaffected.
- R5: A routing field of value k makes the channel count pulses of `src_en[k]`.
- R6: With a rate field of n, the channel emits one single-cycle `ch_en` pulse for every 2^n pulses of its selected source. The pulse appears one cycle after the source pulse that completes the count, so a source with period P gives an output period of P*2^n.
- R7: A change to a channel's routing or rate field takes effect only at that channel's next output pulse. The period in progress completes with the old setting.
- R8: When a channel's disable bit is cleared at a write edge, its counter starts from zero. With an always-on source and rate n, the first pulse is visible after the 2^n-th following clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_en | input | 4 | Source clock-enable streams, one per source |
| bus_addr | input | 4 | Byte offset of the control word |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ch_en | output | 16 | Derived enable pulse per channel |

## Verification
The hardest situation to reach from the ports is a rate change that lands in the middle of a divided period. Reaching it requires a write that falls strictly between two output pulses of a slow channel. The stimulus follows the pulse train of channel 0 and issues the write a fixed number of cycles after a pulse it has observed. It then measures that the next interval still has the old length and the one after it has the new length. The other cases are reached by two configurations that together cover all sixteen route and rate pairs, fed by sources of periods 1 to 4. In each configuration the distance between consecutive output pulses is compared with the product of source period and divide ratio.

// File: rtl/clk_en_xbar_pkg.sv
// Shared constants for the clock-enable crossbar: bus geometry and the
// byte offsets of the three control words.
package clk_en_xbar_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_GATE = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_SEL  = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_DIV  = 4'h8;
endpackage

// File: rtl/cxb_regs.sv
// Control word storage for the crossbar.
// Holds the disable word (one bit per channel) and the routing and rate
// words (SELW and DIVW bits per channel). Writes to unknown offsets are
// dropped; reads are combinational and unknown offsets read zero.
// Assumes NCH*SELW and NCH*DIVW fit in the data width.
module cxb_regs
    import clk_en_xbar_pkg::*;
#(
    parameter int NCH  = 16,
    parameter int SELW = 2,
    parameter int DIVW = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   wr_en,
    input  logic [DATA_W-1:0]      wdata,
    output logic [DATA_W-1:0]      rdata,
    output logic [NCH-1:0]         gate_q,
    output logic [NCH*SELW-1:0]    sel_q,
    output logic [NCH*DIVW-1:0]    div_q
);

    // Store written words; reset disables every channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= '1;
            sel_q  <= '0;
            div_q  <= '0;
        end else if (wr_en) begin
            case (addr)
                OFS_GATE: gate_q <= wdata[NCH-1:0];
                OFS_SEL:  sel_q  <= wdata[NCH*SELW-1:0];
                OFS_DIV:  div_q  <= wdata[NCH*DIVW-1:0];
                default:  ;
            endcase
        end
    end

    // Return the addressed word, zero-extended.
    always_comb begin
        rdata = '0;
        case (addr)
            OFS_GATE: rdata[NCH-1:0]      = gate_q;
            OFS_SEL:  rdata[NCH*SELW-1:0] = sel_q;
            OFS_DIV:  rdata[NCH*DIVW-1:0] = div_q;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/cxb_channel.sv
// One crossbar output channel.
// Picks a source enable, counts its pulses, and emits a registered one-cycle
// pulse every 2^div source pulses. Routing and rate are captured into active
// copies only at a period boundary (or continuously while disabled), so a
// running period is never cut short. Disabled means counter cleared, output 0.
module cxb_channel #(
    parameter int NSRC = 4,
    parameter int SELW = 2,
    parameter int DIVW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_en,
    input  logic            gate_off,
    input  logic [SELW-1:0] cfg_sel,
    input  logic [DIVW-1:0] cfg_div,
    output logic            pulse_o
);
    localparam int CNTW = (1 << DIVW) - 1;

    logic [CNTW-1:0] cnt_q;
    logic [SELW-1:0] act_sel;
    logic [DIVW-1:0] act_div;
    logic [CNTW-1:0] last_cnt;
    logic            src_hit;

    // Terminal count for the active rate, and the selected source pulse.
    always_comb begin
        last_cnt = CNTW'((32'd1 << act_div) - 32'd1);
        src_hit  = src_en[act_sel];
    end

    // Count source pulses, emit at the boundary and reload settings there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            act_sel <= '0;
            act_div <= '0;
            pulse_o <= 1'b0;
        end else if (gate_off) begin
            cnt_q   <= '0;
            act_sel <= cfg_sel;
            act_div <= cfg_div;
            pulse_o <= 1'b0;
        end else begin
            pulse_o <= 1'b0;
            if (src_hit) begin
                if (cnt_q == last_cnt) begin
                    cnt_q   <= '0;
                    pulse_o <= 1'b1;
                    act_sel <= cfg_sel;
                    act_div <= cfg_div;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/clk_en_xbar.sv
// Gated clock-enable crossbar top.
// Up to sixteen channels, each routing one of NSRC source enables through a
// power-of-two pulse divider and a disable bit. Everything runs on clk; the
// outputs are enable pulses, not clocks. Assumes src_en is synchronous to clk.
module clk_en_xbar
    import clk_en_xbar_pkg::*;
#(
    parameter int NCH  = 16,
    parameter int NSRC = 4,
    parameter int DIVW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_en,
    input  logic [3:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NCH-1:0]    ch_en
);
    localparam int SELW = $clog2(NSRC);

    logic [NCH-1:0]      gate_q;
    logic [NCH*SELW-1:0] sel_q;
    logic [NCH*DIVW-1:0] div_q;

    cxb_regs #(.NCH(NCH), .SELW(SELW), .DIVW(DIVW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (bus_addr),
        .wr_en  (bus_wr),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .gate_q (gate_q),
        .sel_q  (sel_q),
        .div_q  (div_q)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        cxb_channel #(.NSRC(NSRC), .SELW(SELW), .DIVW(DIVW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_en   (src_en),
            .gate_off (gate_q[i]),
            .cfg_sel  (sel_q[i*SELW +: SELW]),
            .cfg_div  (div_q[i*DIVW +: DIVW]),
            .pulse_o  (ch_en[i])
        );
    end

endmodule

// File: rtl/clk_en_xbar_chk.sv
// Property checker for the crossbar, bound into every clk_en_xbar instance.
// Watches the ports and the stored control words.
module clk_en_xbar_chk
    import clk_en_xbar_pkg::*;
#(
    parameter int NCH  = 16,
    parameter int NSRC = 4,
    parameter int SELW = 2,
    parameter int DIVW = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NSRC-1:0]     src_en,
    input logic [3:0]          bus_addr,
    input logic                bus_wr,
    input logic [NCH-1:0]      ch_en,
    input logic [NCH-1:0]      gate_q,
    input logic [NCH*SELW-1:0] sel_q,
    input logic [NCH*DIVW-1:0] div_q
);

    p_reset_values_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (gate_q == '1 && sel_q == '0 && div_q == '0 && ch_en == '0));

    p_undef_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != OFS_GATE && bus_addr != OFS_SEL && bus_addr != OFS_DIV)
        |=> ($stable(gate_q) && $stable(sel_q) && $stable(div_q)));

    p_gated_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en & $past(gate_q)) == '0);

    p_pulse_has_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en != '0) |-> ($past(src_en) != '0));

endmodule

bind clk_en_xbar clk_en_xbar_chk #(
    .NCH(NCH), .NSRC(NSRC), .SELW(SELW), .DIVW(DIVW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_en   (src_en),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .ch_en    (ch_en),
    .gate_q   (gate_q),
    .sel_q    (sel_q),
    .div_q    (div_q)
);

// File: tb/test_clk_en_xbar.sv
// Bench for clk_en_xbar: sources with periods 1..4, sweeps of all route and
// rate pairs, gating, ignored writes and mid-period rate changes.
module test_clk_en_xbar;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_en = '0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] ch_en;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    int tick = 0;

    clk_en_xbar i_clk_en_xbar (
        .clk(clk), .rst_n(rst_n), .src_en(src_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_en(ch_en)
    );

    always #4 clk = ~clk;

    // Source k pulses once every k+1 cycles.
    initial begin
        forever begin
            @(negedge clk);
            for (int k = 0; k < 4; k++) src_en[k] = ((tick % (k + 1)) == 0);
            tick++;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Program all channels, enable them, and compare pulse spacing (R5, R6).
    task automatic sweep(input bit swap);
        int sel_c[16];
        int div_c[16];
        int last[16];
        int npl[16];
        int bad[16];
        logic [31:0] sw, dw, rd;
        sw = '0; dw = '0;
        for (int i = 0; i < 16; i++) begin
            sel_c[i] = swap ? i / 4 : i % 4;
            div_c[i] = swap ? i % 4 : i / 4;
            sw |= 32'(sel_c[i]) << (2 * i);
            dw |= 32'(div_c[i]) << (2 * i);
            last[i] = -1; npl[i] = 0; bad[i] = 0;
        end
        bus_write(4'h0, 32'h0000_ffff);
        bus_write(4'h4, sw);
        bus_write(4'h8, dw);
        bus_read(4'h4, rd);
        check(rd == sw, "R2 routing readback", rd, sw);
        bus_read(4'h8, rd);
        check(rd == dw, "R2 rate readback", rd, dw);
        bus_write(4'h0, 32'h0);
        bus_read(4'h0, rd);
        check(rd == 32'h0, "R2 disable readback", rd, 0);
        for (int t = 0; t < 400; t++) begin
            @(negedge clk);
            for (int i = 0; i < 16; i++) begin
                if (ch_en[i]) begin
                    if (last[i] >= 0 && (t - last[i]) != ((sel_c[i] + 1) << div_c[i]))
                        bad[i]++;
                    last[i] = t;
                    npl[i]++;
                end
            end
        end
        for (int i = 0; i < 16; i++)
            check(bad[i] == 0 && npl[i] >= 3, "R5 R6 pulse spacing",
                  {bad[i], npl[i]}, (sel_c[i] + 1) << div_c[i]);
    endtask

    initial begin
        logic [31:0] rd;
        int cnt, t;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(ch_en == 16'h0, "R1 outputs idle", ch_en, 0);
        bus_read(4'h0, rd); check(rd == 32'h0000_ffff, "R1 disable word", rd, 32'hffff);
        bus_read(4'h4, rd); check(rd == 32'h0, "R1 routing word", rd, 0);
        bus_read(4'h8, rd); check(rd == 32'h0, "R1 rate word", rd, 0);

        sweep(1'b0);
        sweep(1'b1);

        // R3: writes to undefined offsets are dropped; reads there give zero
        bus_write(4'hC, 32'hffff_ffff);
        bus_write(4'h1, 32'h1234_5678);
        bus_read(4'h0, rd); check(rd == 32'h0, "R3 disable unchanged", rd, 0);
        bus_read(4'h4, rd); check(rd == 32'hffaa_5500, "R3 routing unchanged", rd, 32'hffaa5500);
        bus_read(4'h8, rd); check(rd == 32'he4e4_e4e4, "R3 rate unchanged", rd, 32'he4e4e4e4);
        bus_read(4'hC, rd); check(rd == 32'h0, "R3 undefined read", rd, 0);

        // R4: disable channel 5 only; channel 6 keeps running
        bus_write(4'h0, 32'h0000_0020);
        @(negedge clk);
        cnt = 0; t = 0;
        for (int j = 0; j < 100; j++) begin
            @(negedge clk);
            if (ch_en[5]) cnt++;
            if (ch_en[6]) t++;
        end
        check(cnt == 0, "R4 disabled channel silent", cnt, 0);
        check(t > 0, "R4 neighbour unaffected", t, 1);

        // R8: channel 0, source 0 (always on), rate 2 -> first pulse after 4th edge
        bus_write(4'h0, 32'h0000_ffff);
        bus_write(4'h4, 32'h0);
        bus_write(4'h8, 32'h2);
        bus_write(4'h0, 32'h0000_fffe);
        cnt = 0;
        for (int j = 1; j <= 5; j++) begin
            @(negedge clk);
            if (ch_en[0] && cnt == 0) cnt = j;
        end
        check(cnt == 4, "R8 first pulse edge", cnt, 4);

        // R7: rate 3 running, switch to rate 0 mid-period
        bus_write(4'h8, 32'h3);
        for (int p = 0; p < 2; p++) begin
            cnt = 0;
            do begin @(negedge clk); cnt++; end while (!ch_en[0] && cnt < 100);
        end
        t = 0;
        repeat (2) begin @(negedge clk); t++; end
        bus_write(4'h8, 32'h0);
        t += 2;
        do begin @(negedge clk); t++; end while (!ch_en[0] && t < 100);
        check(t == 8, "R7 old period completes", t, 8);
        @(negedge clk);
        check(ch_en[0] == 1'b1, "R7 new rate after boundary", ch_en[0], 1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule